// File: doc/BRIEF.md
# Interrupt Pin Redirection and Delivery Core

This block takes a bank of interrupt request lines and a per-pin redirection configuration: vector, delivery mode, trigger mode, mask, destination mode and destination. It turns requests into single-beat interrupt messages, each made of a 32-bit address and a 32-bit data word, on a valid/ready port. Each pin keeps a pending bit and an in-service flag. The in-service flag applies only to level-triggered pins. It is set when such a pin is delivered and stops any further delivery until an end-of-interrupt (EOI) that carries the pin's vector clears it.

Edge pins latch a rising request only while unmasked, and drop the pending bit once the request is delivered. Level pins mirror their input into the pending bit every cycle. A scan sequencer with three states moves through the pins from the lowest index to the highest:

- `SCAN_IDLE`: waits for any eligible pin. Leaving `SCAN_IDLE` for `SCAN_OFFER` picks the lowest eligible pin.
- `SCAN_OFFER`: holds the message until it is accepted. On acceptance it goes to `SCAN_SEEK`, or back to `SCAN_IDLE` when the last pin was just sent.
- `SCAN_SEEK`: looks for the next eligible pin above the one just delivered. It goes to `SCAN_OFFER` if it finds one and to `SCAN_IDLE` if it does not.

Top module: `irq_redirect_core`

## Requirements
- R1: After reset no message is offered (`msg_valid` low), and nothing is delivered while all lines stay low.
- R2: Line 0 drives pin 2, ORed with line 2. Pin 0 has no source and never delivers. Every other line i drives pin i.
- R3: An unmasked edge pin delivers exactly one message per rising edge of its line. A line held high gives no further messages.
- R4: A rising edge on a masked edge pin is discarded, so unmasking that pin later delivers nothing.
- R5: An unmasked level pin with its line high delivers once and sets its in-service flag. While the flag is set, no further message is sent for that pin even though the line stays high.
- R6: An EOI whose vector equals a pin's configured vector clears that pin's in-service flag, and the pin is delivered again if its line is still high. An EOI with any other vector has no effect.
- R7: A level pin whose line has gone low is not pending, so an EOI that clears its flag causes no message.
- R8: Whenever a pin is configured as edge-triggered, its in-service flag is cleared.
- R9: Data word: bits 7:0 hold the vector, bits 10:8 the delivery mode, and bit 15 the trigger mode (1 = level). All other bits are zero.
- R10: Address word: 0xFEE00000 ORed with the 16-bit destination at bits 19:4 and the destination-mode bit at bit 2.
- R11: When the delivery mode is 3'b111, the data vector comes from `ext_vector` instead of the pin's configuration.
- R12: Pins that become pending in the same cycle are delivered in ascending pin order, with at most one delivery per cycle.
- R13: While `msg_ready` is low, `msg_valid` stays high and the address and data stay unchanged. A delivery takes effect only on a cycle where both are high.
- R14: A masked level pin whose line is high delivers nothing, and it is delivered once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_PINS | Interrupt request lines |
| cfg_vector | input | NUM_PINS x 8 | Per-pin vector |
| cfg_dlv_mode | input | NUM_PINS x 3 | Per-pin delivery mode (3'b111 = external vector) |
| cfg_trig_level | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_masked | input | NUM_PINS | Per-pin mask, 1 = masked |
| cfg_dest_mode | input | NUM_PINS | Per-pin destination-mode bit |
| cfg_dest | input | NUM_PINS x 16 | Per-pin destination field |
| ext_vector | input | 8 | Vector used for pins in external-vector mode |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with `msg_valid` |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hardest case to reach is a level pin whose in-service flag is set while its line is still high, followed by a change that must release it. That change is either an EOI with a matching vector or a switch through edge mode. The bench gets there by holding the line high across the first delivery. It then sends a non-matching EOI, a matching EOI, and an edge/level toggle, and counts the messages after each step. The stall case is reached by lowering `msg_ready` before a request arrives, which keeps the offered message standing for several cycles.

// File: rtl/irq_redirect_pkg.sv
`timescale 1ns/1ps
package irq_redirect_pkg;

    localparam int VEC_W  = 8;
    localparam int DLV_W  = 3;
    localparam int DEST_W = 16;
    localparam int WORD_W = 32;

    localparam logic [WORD_W-1:0] MSG_ADDR_BASE = 32'hFEE0_0000;
    localparam int                ADDR_DEST_LSB = 4;
    localparam int                ADDR_DM_BIT   = 2;
    localparam logic [DLV_W-1:0]  DLV_EXT_VEC   = 3'b111;

    typedef enum logic [1:0] {
        SCAN_IDLE,
        SCAN_SEEK,
        SCAN_OFFER
    } scan_state_t;

    function automatic logic [WORD_W-1:0] build_addr(
        input logic [DEST_W-1:0] dest,
        input logic              dm
    );
        logic [WORD_W-1:0] a;
        a = MSG_ADDR_BASE;
        a[ADDR_DEST_LSB +: DEST_W] = dest;
        a[ADDR_DM_BIT] = dm;
        return a;
    endfunction

    function automatic logic [WORD_W-1:0] build_data(
        input logic [VEC_W-1:0] vec,
        input logic [DLV_W-1:0] dlv,
        input logic             lvl
    );
        return {16'b0, lvl, 4'b0, dlv, vec};
    endfunction

endpackage

// File: rtl/irq_line_map.sv
`timescale 1ns/1ps
module irq_line_map #(
    parameter int NUM_PINS = 24
) (
    input  logic [NUM_PINS-1:0] lines,
    output logic [NUM_PINS-1:0] pin_req
);
    // line 0 is steered onto pin 2; pin 0 has no source
    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_map
        if (gi == 0) begin : g_zero
            assign pin_req[gi] = 1'b0;
        end else if (gi == 2) begin : g_two
            assign pin_req[gi] = lines[2] | lines[0];
        end else begin : g_direct
            assign pin_req[gi] = lines[gi];
        end
    end
endmodule

// File: rtl/irq_pin_slot.sv
`timescale 1ns/1ps
module irq_pin_slot
    import irq_redirect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic             trig_level,
    input  logic             masked,
    input  logic [VEC_W-1:0] vec,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             deliver,
    output logic             pending,
    output logic             in_service,
    output logic             eligible
);
    logic req_q;
    logic rise;
    logic eoi_hit;

    assign rise    = req_in & ~req_q;
    assign eoi_hit = eoi_valid & in_service & (vec == eoi_vector);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q      <= 1'b0;
            pending    <= 1'b0;
            in_service <= 1'b0;
        end else begin
            req_q <= req_in;
            if (trig_level) begin
                pending <= req_in;
            end else if (rise && !masked) begin
                pending <= 1'b1;
            end else if (deliver) begin
                pending <= 1'b0;
            end
            if (!trig_level) begin
                in_service <= 1'b0;
            end else if (deliver) begin
                in_service <= 1'b1;
            end else if (eoi_hit) begin
                in_service <= 1'b0;
            end
        end
    end

    assign eligible = pending & ~masked & (~trig_level | ~in_service);
endmodule

// File: rtl/irq_scan_fsm.sv
`timescale 1ns/1ps
module irq_scan_fsm
    import irq_redirect_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W  = $clog2(NUM_PINS),
    localparam int BASE_W = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] eligible,
    input  logic                msg_ready,
    output logic                pick_load,
    output logic [IDX_W-1:0]    pick_idx,
    output logic                offer,
    output logic [NUM_PINS-1:0] deliver
);
    scan_state_t       state_q, state_d;
    logic [IDX_W-1:0]  cur_q, cur_d;
    logic [BASE_W-1:0] base_q, base_d;
    logic [BASE_W-1:0] search_base;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            cur_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            base_q  <= base_d;
        end
    end

    // lowest eligible pin at or above the search base
    assign search_base = (state_q == SCAN_SEEK) ? base_q : '0;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (eligible[i] && (i >= int'(search_base))) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        base_d  = base_q;
        unique case (state_q)
            SCAN_IDLE, SCAN_SEEK: begin
                if (hit) begin
                    cur_d   = hit_idx;
                    state_d = SCAN_OFFER;
                end else begin
                    state_d = SCAN_IDLE;
                end
            end
            SCAN_OFFER: begin
                if (msg_ready) begin
                    if (cur_q == IDX_W'(NUM_PINS - 1)) begin
                        state_d = SCAN_IDLE;
                    end else begin
                        base_d  = BASE_W'(cur_q) + 1'b1;
                        state_d = SCAN_SEEK;
                    end
                end
            end
            default: state_d = SCAN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pick_load = 1'b0;
        offer     = 1'b0;
        deliver   = '0;
        unique case (state_q)
            SCAN_IDLE, SCAN_SEEK: pick_load = hit;
            SCAN_OFFER: begin
                offer = 1'b1;
                if (msg_ready) deliver[cur_q] = 1'b1;
            end
            default: ;
        endcase
    end

    assign pick_idx = hit_idx;
endmodule

// File: rtl/irq_msg_fmt.sv
`timescale 1ns/1ps
module irq_msg_fmt
    import irq_redirect_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W = $clog2(NUM_PINS)
) (
    input  logic [IDX_W-1:0]                sel,
    input  logic [NUM_PINS-1:0][VEC_W-1:0]  cfg_vector,
    input  logic [NUM_PINS-1:0][DLV_W-1:0]  cfg_dlv_mode,
    input  logic [NUM_PINS-1:0]             cfg_trig_level,
    input  logic [NUM_PINS-1:0]             cfg_dest_mode,
    input  logic [NUM_PINS-1:0][DEST_W-1:0] cfg_dest,
    input  logic [VEC_W-1:0]                ext_vector,
    output logic [WORD_W-1:0]               addr,
    output logic [WORD_W-1:0]               data
);
    logic [VEC_W-1:0] vec_sel;
    logic [DLV_W-1:0] dlv_sel;

    always_comb begin
        dlv_sel = cfg_dlv_mode[sel];
        vec_sel = (dlv_sel == DLV_EXT_VEC) ? ext_vector : cfg_vector[sel];
        addr    = build_addr(cfg_dest[sel], cfg_dest_mode[sel]);
        data    = build_data(vec_sel, dlv_sel, cfg_trig_level[sel]);
    end
endmodule

// File: rtl/irq_redirect_core.sv
`timescale 1ns/1ps
module irq_redirect_core
    import irq_redirect_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PINS-1:0]             irq_lines,
    input  logic [NUM_PINS-1:0][VEC_W-1:0]  cfg_vector,
    input  logic [NUM_PINS-1:0][DLV_W-1:0]  cfg_dlv_mode,
    input  logic [NUM_PINS-1:0]             cfg_trig_level,
    input  logic [NUM_PINS-1:0]             cfg_masked,
    input  logic [NUM_PINS-1:0]             cfg_dest_mode,
    input  logic [NUM_PINS-1:0][DEST_W-1:0] cfg_dest,
    input  logic [VEC_W-1:0]                ext_vector,
    input  logic                            eoi_valid,
    input  logic [VEC_W-1:0]                eoi_vector,
    output logic                            msg_valid,
    input  logic                            msg_ready,
    output logic [WORD_W-1:0]               msg_addr,
    output logic [WORD_W-1:0]               msg_data
);
    localparam int IDX_W = $clog2(NUM_PINS);

    logic [NUM_PINS-1:0] pin_req;
    logic [NUM_PINS-1:0] pin_pending;
    logic [NUM_PINS-1:0] pin_rirr;
    logic [NUM_PINS-1:0] pin_eligible;
    logic [NUM_PINS-1:0] pin_deliver;
    logic                pick_load;
    logic [IDX_W-1:0]    pick_idx;
    logic [WORD_W-1:0]   fmt_addr;
    logic [WORD_W-1:0]   fmt_data;

    irq_line_map #(.NUM_PINS(NUM_PINS)) u_map (
        .lines   (irq_lines),
        .pin_req (pin_req)
    );

    for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
        irq_pin_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_in     (pin_req[gp]),
            .trig_level (cfg_trig_level[gp]),
            .masked     (cfg_masked[gp]),
            .vec        (cfg_vector[gp]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .deliver    (pin_deliver[gp]),
            .pending    (pin_pending[gp]),
            .in_service (pin_rirr[gp]),
            .eligible   (pin_eligible[gp])
        );
    end

    irq_scan_fsm #(.NUM_PINS(NUM_PINS)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .eligible  (pin_eligible),
        .msg_ready (msg_ready),
        .pick_load (pick_load),
        .pick_idx  (pick_idx),
        .offer     (msg_valid),
        .deliver   (pin_deliver)
    );

    irq_msg_fmt #(.NUM_PINS(NUM_PINS)) u_fmt (
        .sel            (pick_idx),
        .cfg_vector     (cfg_vector),
        .cfg_dlv_mode   (cfg_dlv_mode),
        .cfg_trig_level (cfg_trig_level),
        .cfg_dest_mode  (cfg_dest_mode),
        .cfg_dest       (cfg_dest),
        .ext_vector     (ext_vector),
        .addr           (fmt_addr),
        .data           (fmt_data)
    );

    // message holding register, loaded when a pin is picked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_addr <= '0;
            msg_data <= '0;
        end else if (pick_load) begin
            msg_addr <= fmt_addr;
            msg_data <= fmt_data;
        end
    end

    // pending state is kept per pin; observed only through messages
    logic unused_pending;
    assign unused_pending = ^pin_pending;
endmodule

// File: rtl/irq_core_checker.sv
`timescale 1ns/1ps
module irq_core_checker #(
    parameter int NUM_PINS = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [31:0]         msg_addr,
    input logic [31:0]         msg_data,
    input logic [NUM_PINS-1:0] cfg_trig_level,
    input logic [NUM_PINS-1:0] pin_rirr,
    input logic [NUM_PINS-1:0] pin_deliver
);
    assert_hold_while_stalled_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    assert_deliver_on_handshake_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_deliver) |-> (msg_valid && msg_ready));

    assert_single_delivery_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_deliver));

    assert_addr_layout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[31:20] == 12'hFEE && msg_addr[3] == 1'b0 && msg_addr[1:0] == 2'b00));

    assert_data_layout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:16] == 16'h0 && msg_data[14:11] == 4'h0));

    assert_edge_clears_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_rirr & ~$past(cfg_trig_level)) == '0));

    assert_flag_needs_delivery_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_rirr & ~$past(pin_rirr) & ~$past(pin_deliver)) == '0));
endmodule

bind irq_redirect_core irq_core_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .msg_valid      (msg_valid),
    .msg_ready      (msg_ready),
    .msg_addr       (msg_addr),
    .msg_data       (msg_data),
    .cfg_trig_level (cfg_trig_level),
    .pin_rirr       (pin_rirr),
    .pin_deliver    (pin_deliver)
);

// File: tb/irq_redirect_core_bench.sv
`timescale 1ns/1ps
module irq_redirect_core_bench;
    localparam int NP = 24;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      irq_lines = '0;
    logic [NP-1:0][7:0] cfg_vector = '0;
    logic [NP-1:0][2:0] cfg_dlv_mode = '0;
    logic [NP-1:0]      cfg_trig_level = '0;
    logic [NP-1:0]      cfg_masked = '1;
    logic [NP-1:0]      cfg_dest_mode = '0;
    logic [NP-1:0][15:0] cfg_dest = '0;
    logic [7:0]         ext_vector = '0;
    logic               eoi_valid = 1'b0;
    logic [7:0]         eoi_vector = '0;
    logic               msg_valid;
    logic               msg_ready = 1'b1;
    logic [31:0]        msg_addr;
    logic [31:0]        msg_data;

    int nvec = 0;
    int nfail = 0;
    int got_n = 0;
    logic [31:0] got_addr [64];
    logic [31:0] got_data [64];

    always #2.5 clk = ~clk;

    irq_redirect_core #(.NUM_PINS(NP)) u_irq_redirect_core (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .cfg_vector(cfg_vector), .cfg_dlv_mode(cfg_dlv_mode),
        .cfg_trig_level(cfg_trig_level), .cfg_masked(cfg_masked),
        .cfg_dest_mode(cfg_dest_mode), .cfg_dest(cfg_dest),
        .ext_vector(ext_vector), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // record every accepted message (handshake completes at the next edge)
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            got_addr[got_n % 64] = msg_addr;
            got_data[got_n % 64] = msg_data;
            got_n = got_n + 1;
        end
    end

    function automatic logic [31:0] exp_addr(logic [15:0] dest, logic dm);
        return 32'hFEE0_0000 | ({16'h0, dest} << 4) | ({31'h0, dm} << 2);
    endfunction

    function automatic logic [31:0] exp_data(logic [7:0] vec, logic [2:0] dlv, logic lvl);
        return {16'h0, lvl, 4'h0, dlv, vec};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_line(int l);
        tick(1); irq_lines[l] = 1'b1;
        tick(1); irq_lines[l] = 1'b0;
    endtask

    task automatic send_eoi(logic [7:0] v);
        tick(1); eoi_valid = 1'b1; eoi_vector = v;
        tick(1); eoi_valid = 1'b0;
    endtask

    task automatic set_pin(int p, logic [7:0] v, logic [2:0] d, logic lvl, logic m,
                           logic dm, logic [15:0] dst);
        cfg_vector[p] = v; cfg_dlv_mode[p] = d; cfg_trig_level[p] = lvl;
        cfg_masked[p] = m; cfg_dest_mode[p] = dm; cfg_dest[p] = dst;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : main
        int base;
        void'($urandom(32'd20240917));
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        @(negedge clk);
        check("R1 valid after reset", {31'h0, msg_valid}, 32'h0);
        tick(20);
        check("R1 no delivery while idle", got_n, 0);

        // R3: edge pin, one message per rising edge
        set_pin(3, 8'h33, 3'b000, 1'b0, 1'b0, 1'b1, 16'hAB12);
        base = got_n;
        pulse_line(3); tick(20);
        check("R3 one message per edge", got_n - base, 1);
        check("R10 address format", got_addr[base % 64], exp_addr(16'hAB12, 1'b1));
        check("R9 data format edge", got_data[base % 64], exp_data(8'h33, 3'b000, 1'b0));
        base = got_n;
        tick(1); irq_lines[3] = 1'b1; tick(30);
        check("R3 held high gives one", got_n - base, 1);
        irq_lines[3] = 1'b0; tick(5);

        // R2: line 0 maps to pin 2, pin 0 silent
        set_pin(0, 8'h10, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0);
        set_pin(2, 8'h22, 3'b001, 1'b0, 1'b0, 1'b0, 16'h0002);
        base = got_n;
        pulse_line(0); tick(20);
        check("R2 line0 delivers once", got_n - base, 1);
        check("R2 line0 lands on pin 2", got_data[base % 64], exp_data(8'h22, 3'b001, 1'b0));

        // R4: masked edge pin drops request
        set_pin(12, 8'h5C, 3'b000, 1'b0, 1'b1, 1'b0, 16'h0);
        base = got_n;
        pulse_line(12); tick(20);
        check("R4 masked edge no message", got_n - base, 0);
        cfg_masked[12] = 1'b0; tick(20);
        check("R4 unmask after drop no message", got_n - base, 0);

        // R5/R6/R7/R8: level pin with in-service flag
        set_pin(7, 8'h41, 3'b000, 1'b1, 1'b0, 1'b0, 16'h0700);
        base = got_n;
        tick(1); irq_lines[7] = 1'b1; tick(30);
        check("R5 level delivers once", got_n - base, 1);
        check("R9 data format level", got_data[base % 64], exp_data(8'h41, 3'b000, 1'b1));
        send_eoi(8'h42); tick(20);
        check("R6 mismatched EOI ignored", got_n - base, 1);
        send_eoi(8'h41); tick(20);
        check("R6 matching EOI redelivers", got_n - base, 2);
        irq_lines[7] = 1'b0; tick(5);
        cfg_trig_level[7] = 1'b0; tick(3);
        cfg_trig_level[7] = 1'b1; tick(2);
        irq_lines[7] = 1'b1; tick(20);
        check("R8 edge mode clears flag", got_n - base, 3);
        irq_lines[7] = 1'b0; tick(5);
        send_eoi(8'h41); tick(20);
        check("R7 low line no redelivery", got_n - base, 3);
        irq_lines[7] = 1'b1; tick(20);
        check("R7 flag cleared line high delivers", got_n - base, 4);
        irq_lines[7] = 1'b0; send_eoi(8'h41); tick(5);

        // R14: masked level pin
        set_pin(11, 8'h4B, 3'b010, 1'b1, 1'b1, 1'b0, 16'h0);
        base = got_n;
        tick(1); irq_lines[11] = 1'b1; tick(20);
        check("R14 masked level silent", got_n - base, 0);
        cfg_masked[11] = 1'b0; tick(20);
        check("R14 unmask delivers", got_n - base, 1);
        check("R14 data", got_data[base % 64], exp_data(8'h4B, 3'b010, 1'b1));
        irq_lines[11] = 1'b0; cfg_masked[11] = 1'b1; tick(3);

        // R11: external vector mode
        set_pin(4, 8'h04, 3'b111, 1'b0, 1'b0, 1'b0, 16'h0);
        ext_vector = 8'h77;
        base = got_n;
        pulse_line(4); tick(20);
        check("R11 external vector", got_data[base % 64], exp_data(8'h77, 3'b111, 1'b0));

        // R12: ascending order
        set_pin(5, 8'hA5, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0);
        set_pin(9, 8'hA9, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0);
        set_pin(17, 8'hB1, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0);
        base = got_n;
        tick(1); irq_lines[17] = 1'b1; irq_lines[5] = 1'b1; irq_lines[9] = 1'b1;
        tick(1); irq_lines = '0; tick(20);
        check("R12 three delivered", got_n - base, 3);
        check("R12 first pin 5", {24'h0, got_data[base % 64][7:0]}, 32'hA5);
        check("R12 second pin 9", {24'h0, got_data[(base + 1) % 64][7:0]}, 32'hA9);
        check("R12 third pin 17", {24'h0, got_data[(base + 2) % 64][7:0]}, 32'hB1);

        // R13: stall holds message
        set_pin(6, 8'h66, 3'b000, 1'b0, 1'b0, 1'b1, 16'h0606);
        msg_ready = 1'b0;
        base = got_n;
        pulse_line(6); tick(5);
        @(negedge clk);
        check("R13 valid while stalled", {31'h0, msg_valid}, 32'h1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R13 address stable", msg_addr, exp_addr(16'h0606, 1'b1));
            check("R13 data stable", msg_data, exp_data(8'h66, 3'b000, 1'b0));
        end
        check("R13 nothing accepted", got_n - base, 0);
        tick(1); msg_ready = 1'b1; tick(10);
        check("R13 accepted after ready", got_n - base, 1);

        // random single-pin edge deliveries
        cfg_masked = '1; irq_lines = '0; tick(5);
        for (int it = 0; it < 40; it++) begin
            int p;
            logic [7:0] v, xv;
            logic [2:0] d;
            logic dm;
            logic [15:0] dst;
            p = 1 + int'($urandom % 23);
            v = 8'($urandom); xv = 8'($urandom); d = 3'($urandom);
            dm = 1'($urandom); dst = 16'($urandom);
            ext_vector = xv;
            set_pin(p, v, d, 1'b0, 1'b0, dm, dst);
            base = got_n;
            pulse_line(p); tick(12);
            check("R3 random count", got_n - base, 1);
            check("R10 random address", got_addr[base % 64], exp_addr(dst, dm));
            check("R9 R11 random data", got_data[base % 64],
                  exp_data((d == 3'b111) ? xv : v, d, 1'b0));
            cfg_masked[p] = 1'b1;
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule